// File: doc/BRIEF.md
# CAN Message Buffer Status Controller

This block keeps the 4-bit status of each message buffer in a CAN controller, 15 buffers by default, and moves each status along its receive or transmit sequence. Software writes a 16-bit status/control word into one buffer. The protocol engine reports what happens on the bus through indexed single-cycle pulses: a buffer accepted a frame, a data copy finished, a remote frame matched, a transmission started, or a transmission finished. The block does not store frame data and does not handle the bus at bit level.

Each buffer shows its current status, its DLC, a transmit-request flag and the 4-bit priority that goes with that request. A buffer whose copy or transmission completes sets its bit in a shared pending register. That register also holds an error bit, and it works with an enable register and a clear port to produce one interrupt line. Remote frames need no software action. A buffer armed for automatic reply answers a matching request by itself. A buffer that has sent a remote request changes to receive-ready on its own so that it can take the reply.

Top module: `can_mbuf_status_ctrl`

## Requirements
- R1: After reset, every buffer status is 0000, all priorities and DLCs are 0, no transmit request is raised, and the enable register, the pending register and `irq_o` are all 0.
- R2: A software write to buffer `sw_wr_idx` loads status from word bits 3:0, priority from bits 7:4 and DLC from bits 15:12, and the new values show one cycle later. A write that carries the unused codes 1001 or 1011 is dropped as a whole.
- R3: A buffer in 0010 (receive ready) that gets an acceptance hit goes to 0011. On copy-done it goes to 0100 (full) and its pending bit is set.
- R4: A hit on a full buffer (0100) leads to 0101, and copy-done then gives 0110 (overrun). A hit on an overrun buffer leads to 0111, and copy-done returns it to 0110. Each completed copy sets the buffer's pending bit.
- R5: A software write of 0000 during a receive copy (0011, 0101 or 0111) shows 0001 until copy-done, then 0000, and sets no pending bit.
- R6: Any other software write to a buffer in a busy state (0001, 0011, 0101, 0111, 1101, 1111) leaves its status, priority and DLC unchanged.
- R7: In 1100 (send once) the buffer raises its transmit request and presents its priority. Transmit-start moves it to 1101 and drops the request. Transmit-done of a data frame gives 1000 and sets the pending bit.
- R8: Transmit-done from 1101 with `tx_done_remote` high gives 0010 (receive ready) and sets the pending bit.
- R9: A buffer in 1010 (auto reply, no request) that gets a matching remote frame goes to 1110 and raises its request. Transmit-start gives 1111, and transmit-done returns it to 1010 and sets the pending bit.
- R10: A hit, copy-done, remote-match, transmit-start or transmit-done pulse has no effect on a buffer whose status does not accept that event.
- R11: If a hardware event changes a buffer's status in the same cycle that software writes that buffer, the event is applied and the write is dropped.
- R12: Pending bit i belongs to buffer i, and bit 15 (NUM_BUF) is the error bit, set by `err_evt`. Writing ones through the clear port clears those pending bits, but a set in the same cycle wins. `irq_o` is high whenever a pending bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software status/control write strobe |
| sw_wr_idx | input | 4 | Buffer targeted by the write |
| sw_wr_word | input | 16 | Status 3:0, priority 7:4, DLC 15:12 |
| hit_en | input | 1 | Acceptance hit pulse |
| hit_idx | input | 4 | Buffer that accepted the frame |
| copy_done_en | input | 1 | Data copy finished pulse |
| copy_done_idx | input | 4 | Buffer whose copy finished |
| rtr_rx_en | input | 1 | Matching remote frame received pulse |
| rtr_rx_idx | input | 4 | Buffer matched by the remote frame |
| tx_start_en | input | 1 | Transmission started pulse |
| tx_start_idx | input | 4 | Buffer being sent |
| tx_done_en | input | 1 | Transmission finished pulse |
| tx_done_idx | input | 4 | Buffer that was sent |
| tx_done_remote | input | 1 | The finished frame was a remote request |
| err_evt | input | 1 | Error event, sets pending bit 15 |
| ien_wr_en | input | 1 | Interrupt enable register write strobe |
| ien_wr_data | input | 16 | New interrupt enable value |
| iclr_wr_en | input | 1 | Interrupt clear write strobe |
| iclr_wr_data | input | 16 | Pending bits to clear |
| status_o | output | 60 | Status of buffer i at bits 4i+3:4i |
| tx_req_o | output | 15 | Transmit request per buffer |
| tx_prio_o | output | 60 | Priority of buffer i at bits 4i+3:4i |
| dlc_o | output | 60 | DLC of buffer i at bits 4i+3:4i |
| ien_o | output | 16 | Interrupt enable register |
| ipnd_o | output | 16 | Interrupt pending register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Every input is registered once. A write or event pulse that is sampled at one rising edge therefore changes the status, priority, DLC and transmit request at that same edge, and the pending bit set by a completion changes at that edge as well. `irq_o` is a combinational function of the pending and enable registers, so it follows them in the same cycle. The bench drives its inputs 2 ns after a rising edge, keeps each pulse high for exactly one edge, and checks every expected value 2 ns after the edge that should have produced it. It does this in single-cycle steps, so any extra or missing register stage fails a check.

// File: rtl/can_mbuf_pkg.sv
// Package can_mbuf_pkg
// Holds the shared status encoding, the word field positions and the state
// classification helpers for the message buffer status controller.
// Assumes a 16-bit status/control word as described in the brief.
package can_mbuf_pkg;

    localparam int ST_W    = 4;
    localparam int PRIO_W  = 4;
    localparam int DLC_W   = 4;
    localparam int WORD_W  = 16;
    localparam int ST_LSB   = 0;
    localparam int PRIO_LSB = 4;
    localparam int DLC_LSB  = 12;

    typedef enum logic [ST_W-1:0] {
        ST_RX_OFF       = 4'b0000,
        ST_RX_LOCKED    = 4'b0001,
        ST_RX_ARMED     = 4'b0010,
        ST_RX_COPY1     = 4'b0011,
        ST_RX_HELD      = 4'b0100,
        ST_RX_COPY2     = 4'b0101,
        ST_RX_OVR       = 4'b0110,
        ST_RX_COPY3     = 4'b0111,
        ST_TX_IDLE      = 4'b1000,
        ST_TX_AUTO      = 4'b1010,
        ST_TX_SEND      = 4'b1100,
        ST_TX_BUSY_ONE  = 4'b1101,
        ST_TX_SEND_AUTO = 4'b1110,
        ST_TX_BUSY_AUTO = 4'b1111
    } mbuf_state_e;

    // True for states that lock out software writes.
    function automatic logic state_is_busy(input logic [ST_W-1:0] s);
        return (s == ST_RX_LOCKED) || (s == ST_RX_COPY1) || (s == ST_RX_COPY2) ||
               (s == ST_RX_COPY3) || (s == ST_TX_BUSY_ONE) || (s == ST_TX_BUSY_AUTO);
    endfunction

    // True for states with a receive data copy in flight.
    function automatic logic state_is_rx_copy(input logic [ST_W-1:0] s);
        return (s == ST_RX_COPY1) || (s == ST_RX_COPY2) || (s == ST_RX_COPY3);
    endfunction

    // True for every defined code (1001 and 1011 are unused).
    function automatic logic state_is_legal(input logic [ST_W-1:0] s);
        return (s != 4'b1001) && (s != 4'b1011);
    endfunction

endpackage

// File: rtl/mbuf_state_fsm.sv
// Module mbuf_state_fsm
// Status state machine for a single message buffer. It advances on protocol
// engine pulses addressed to this buffer and accepts software writes only
// while no copy or transmission is in flight. done_o pulses in the same cycle
// as the status change that completes a copy or a transmission.
// Assumes every event input is already decoded for this buffer.
module mbuf_state_fsm
    import can_mbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              hit,
    input  logic              copy_done,
    input  logic              rtr_rx,
    input  logic              tx_start,
    input  logic              tx_done,
    input  logic              tx_done_remote,
    output logic [ST_W-1:0]   state_o,
    output logic [PRIO_W-1:0] prio_o,
    output logic [DLC_W-1:0]  dlc_o,
    output logic              tx_req_o,
    output logic              done_o
);

    mbuf_state_e       st_q;
    mbuf_state_e       st_evt;
    logic              evt_taken;
    logic [PRIO_W-1:0] prio_q;
    logic [DLC_W-1:0]  dlc_q;
    logic [ST_W-1:0]   wr_st;

    assign wr_st = wr_word[ST_LSB +: ST_W];

    // Next state caused by hardware events alone.
    always_comb begin
        st_evt = st_q;
        done_o = 1'b0;
        unique case (st_q)
            ST_RX_ARMED:     if (hit)       st_evt = ST_RX_COPY1;
            ST_RX_HELD:      if (hit)       st_evt = ST_RX_COPY2;
            ST_RX_OVR:       if (hit)       st_evt = ST_RX_COPY3;
            ST_RX_COPY1:     if (copy_done) begin st_evt = ST_RX_HELD; done_o = 1'b1; end
            ST_RX_COPY2,
            ST_RX_COPY3:     if (copy_done) begin st_evt = ST_RX_OVR;  done_o = 1'b1; end
            ST_RX_LOCKED:    if (copy_done) st_evt = ST_RX_OFF;
            ST_TX_AUTO:      if (rtr_rx)    st_evt = ST_TX_SEND_AUTO;
            ST_TX_SEND:      if (tx_start)  st_evt = ST_TX_BUSY_ONE;
            ST_TX_SEND_AUTO: if (tx_start)  st_evt = ST_TX_BUSY_AUTO;
            ST_TX_BUSY_ONE:  if (tx_done) begin
                                 st_evt = tx_done_remote ? ST_RX_ARMED : ST_TX_IDLE;
                                 done_o = 1'b1;
                             end
            ST_TX_BUSY_AUTO: if (tx_done) begin st_evt = ST_TX_AUTO; done_o = 1'b1; end
            default:         st_evt = st_q;
        endcase
    end

    assign evt_taken = (st_evt != st_q);

    // Status, priority and DLC registers: events first, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_RX_OFF;
            prio_q <= '0;
            dlc_q  <= '0;
        end else if (evt_taken) begin
            st_q <= st_evt;
        end else if (wr_en) begin
            if (state_is_busy(st_q)) begin
                if (state_is_rx_copy(st_q) && (wr_st == ST_RX_OFF))
                    st_q <= ST_RX_LOCKED;
            end else if (state_is_legal(wr_st)) begin
                st_q   <= mbuf_state_e'(wr_st);
                prio_q <= wr_word[PRIO_LSB +: PRIO_W];
                dlc_q  <= wr_word[DLC_LSB +: DLC_W];
            end
        end
    end

    assign state_o  = st_q;
    assign prio_o   = prio_q;
    assign dlc_o    = dlc_q;
    assign tx_req_o = (st_q == ST_TX_SEND) || (st_q == ST_TX_SEND_AUTO);

    AST_NO_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state_is_legal(st_q)); // R2
    AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_is_busy(st_q) |=> ($stable(prio_q) && $stable(dlc_q))); // R6
    AST_LOCKED_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RX_LOCKED) |=> (st_q == ST_RX_LOCKED || st_q == ST_RX_OFF)); // R5
    AST_AUTO_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TX_AUTO && rtr_rx) |=> (st_q == ST_TX_SEND_AUTO)); // R9
    AST_START_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_req_o) |=> !tx_req_o); // R7
    AST_OVERRUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RX_OVR && !wr_en) |=> (st_q == ST_RX_OVR || st_q == ST_RX_COPY3)); // R4

endmodule

// File: rtl/mbuf_irq_regs.sv
// Module mbuf_irq_regs
// Interrupt enable and pending registers with a write-only clear port.
// A set in the same cycle wins over a clear. The request output is
// combinational from the two registers.
// Assumes set_i pulses are single-cycle completion events.
module mbuf_irq_regs #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_i,
    input  logic             ien_wr_en,
    input  logic [NBITS-1:0] ien_wr_data,
    input  logic             clr_en,
    input  logic [NBITS-1:0] clr_data,
    output logic [NBITS-1:0] ien_o,
    output logic [NBITS-1:0] pnd_o,
    output logic             irq_o
);

    logic [NBITS-1:0] ien_q;
    logic [NBITS-1:0] pnd_q;
    logic [NBITS-1:0] clr_mask;

    assign clr_mask = clr_en ? clr_data : '0;

    // Enable register, loaded as a whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)         ien_q <= '0;
        else if (ien_wr_en) ien_q <= ien_wr_data;
    end

    // Pending register: clear selected bits, then apply new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pnd_q <= '0;
        else        pnd_q <= (pnd_q & ~clr_mask) | set_i;
    end

    assign ien_o = ien_q;
    assign pnd_o = pnd_q;
    assign irq_o = |(pnd_q & ien_q);

    AST_PEND_ON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pnd_q & $past(set_i)) == $past(set_i))); // R12
    AST_CLEAR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_i)) |=> ((pnd_q & $past(clr_mask & ~set_i)) == '0)); // R12

endmodule

// File: rtl/can_mbuf_status_ctrl.sv
// Module can_mbuf_status_ctrl
// Top of the message buffer status controller. It decodes indexed software
// writes and protocol engine pulses to NUM_BUF buffer state machines, and it
// collects their completion pulses, together with the error event, into the
// interrupt registers (error bit at position NUM_BUF).
// Assumes at most one pulse of each kind per cycle, each carrying its index.
module can_mbuf_status_ctrl
    import can_mbuf_pkg::*;
#(
    parameter  int NUM_BUF = 15,
    localparam int IDXW    = $clog2(NUM_BUF + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_wr_en,
    input  logic [IDXW-1:0]           sw_wr_idx,
    input  logic [WORD_W-1:0]         sw_wr_word,
    input  logic                      hit_en,
    input  logic [IDXW-1:0]           hit_idx,
    input  logic                      copy_done_en,
    input  logic [IDXW-1:0]           copy_done_idx,
    input  logic                      rtr_rx_en,
    input  logic [IDXW-1:0]           rtr_rx_idx,
    input  logic                      tx_start_en,
    input  logic [IDXW-1:0]           tx_start_idx,
    input  logic                      tx_done_en,
    input  logic [IDXW-1:0]           tx_done_idx,
    input  logic                      tx_done_remote,
    input  logic                      err_evt,
    input  logic                      ien_wr_en,
    input  logic [NUM_BUF:0]          ien_wr_data,
    input  logic                      iclr_wr_en,
    input  logic [NUM_BUF:0]          iclr_wr_data,
    output logic [NUM_BUF*ST_W-1:0]   status_o,
    output logic [NUM_BUF-1:0]        tx_req_o,
    output logic [NUM_BUF*PRIO_W-1:0] tx_prio_o,
    output logic [NUM_BUF*DLC_W-1:0]  dlc_o,
    output logic [NUM_BUF:0]          ien_o,
    output logic [NUM_BUF:0]          ipnd_o,
    output logic                      irq_o
);

    logic [NUM_BUF-1:0] buf_done;

    // One state machine per buffer, each fed by its own index decode.
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        localparam logic [IDXW-1:0] MY_IDX = IDXW'(i);
        mbuf_state_fsm u_fsm (
            .clk            (clk),
            .rst_n          (rst_n),
            .wr_en          (sw_wr_en     && (sw_wr_idx     == MY_IDX)),
            .wr_word        (sw_wr_word),
            .hit            (hit_en       && (hit_idx       == MY_IDX)),
            .copy_done      (copy_done_en && (copy_done_idx == MY_IDX)),
            .rtr_rx         (rtr_rx_en    && (rtr_rx_idx    == MY_IDX)),
            .tx_start       (tx_start_en  && (tx_start_idx  == MY_IDX)),
            .tx_done        (tx_done_en   && (tx_done_idx   == MY_IDX)),
            .tx_done_remote (tx_done_remote),
            .state_o        (status_o[i*ST_W +: ST_W]),
            .prio_o         (tx_prio_o[i*PRIO_W +: PRIO_W]),
            .dlc_o          (dlc_o[i*DLC_W +: DLC_W]),
            .tx_req_o       (tx_req_o[i]),
            .done_o         (buf_done[i])
        );
    end

    mbuf_irq_regs #(.NBITS(NUM_BUF + 1)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       ({err_evt, buf_done}),
        .ien_wr_en   (ien_wr_en),
        .ien_wr_data (ien_wr_data),
        .clr_en      (iclr_wr_en),
        .clr_data    (iclr_wr_data),
        .ien_o       (ien_o),
        .pnd_o       (ipnd_o),
        .irq_o       (irq_o)
    );

    AST_REQ_HAS_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_req_o & buf_done) == '0)); // R7

endmodule

// File: tb/can_mbuf_status_ctrl_tb_top.sv
// Directed bench for can_mbuf_status_ctrl. Inputs change 2 ns after a rising
// edge, and outputs are checked 2 ns after the edge that should update them.
module can_mbuf_status_ctrl_tb_top;

    localparam int NB = 15;
    localparam int IW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sw_wr_en = 1'b0;
    logic [IW-1:0]  sw_wr_idx = '0;
    logic [15:0]    sw_wr_word = '0;
    logic           hit_en = 1'b0;
    logic [IW-1:0]  hit_idx = '0;
    logic           copy_done_en = 1'b0;
    logic [IW-1:0]  copy_done_idx = '0;
    logic           rtr_rx_en = 1'b0;
    logic [IW-1:0]  rtr_rx_idx = '0;
    logic           tx_start_en = 1'b0;
    logic [IW-1:0]  tx_start_idx = '0;
    logic           tx_done_en = 1'b0;
    logic [IW-1:0]  tx_done_idx = '0;
    logic           tx_done_remote = 1'b0;
    logic           err_evt = 1'b0;
    logic           ien_wr_en = 1'b0;
    logic [NB:0]    ien_wr_data = '0;
    logic           iclr_wr_en = 1'b0;
    logic [NB:0]    iclr_wr_data = '0;
    logic [NB*4-1:0] status_o;
    logic [NB-1:0]   tx_req_o;
    logic [NB*4-1:0] tx_prio_o;
    logic [NB*4-1:0] dlc_o;
    logic [NB:0]     ien_o;
    logic [NB:0]     ipnd_o;
    logic            irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    can_mbuf_status_ctrl #(.NUM_BUF(NB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sw_wr_en(sw_wr_en), .sw_wr_idx(sw_wr_idx), .sw_wr_word(sw_wr_word),
        .hit_en(hit_en), .hit_idx(hit_idx),
        .copy_done_en(copy_done_en), .copy_done_idx(copy_done_idx),
        .rtr_rx_en(rtr_rx_en), .rtr_rx_idx(rtr_rx_idx),
        .tx_start_en(tx_start_en), .tx_start_idx(tx_start_idx),
        .tx_done_en(tx_done_en), .tx_done_idx(tx_done_idx), .tx_done_remote(tx_done_remote),
        .err_evt(err_evt), .ien_wr_en(ien_wr_en), .ien_wr_data(ien_wr_data),
        .iclr_wr_en(iclr_wr_en), .iclr_wr_data(iclr_wr_data),
        .status_o(status_o), .tx_req_o(tx_req_o), .tx_prio_o(tx_prio_o), .dlc_o(dlc_o),
        .ien_o(ien_o), .ipnd_o(ipnd_o), .irq_o(irq_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] st(input int i);
        return status_o[i*4 +: 4];
    endfunction

    function automatic logic [3:0] pr(input int i);
        return tx_prio_o[i*4 +: 4];
    endfunction

    function automatic logic [3:0] dl(input int i);
        return dlc_o[i*4 +: 4];
    endfunction

    task automatic sw_wr(input int idx, input logic [3:0] s, input logic [3:0] p, input logic [3:0] d);
        sw_wr_en = 1'b1; sw_wr_idx = IW'(idx); sw_wr_word = {d, 4'h0, p, s};
        tick();
        sw_wr_en = 1'b0;
    endtask

    task automatic do_hit(input int idx);
        hit_en = 1'b1; hit_idx = IW'(idx); tick(); hit_en = 1'b0;
    endtask

    task automatic do_copy(input int idx);
        copy_done_en = 1'b1; copy_done_idx = IW'(idx); tick(); copy_done_en = 1'b0;
    endtask

    task automatic do_rtr(input int idx);
        rtr_rx_en = 1'b1; rtr_rx_idx = IW'(idx); tick(); rtr_rx_en = 1'b0;
    endtask

    task automatic do_start(input int idx);
        tx_start_en = 1'b1; tx_start_idx = IW'(idx); tick(); tx_start_en = 1'b0;
    endtask

    task automatic do_txdone(input int idx, input logic remote);
        tx_done_en = 1'b1; tx_done_idx = IW'(idx); tx_done_remote = remote;
        tick();
        tx_done_en = 1'b0; tx_done_remote = 1'b0;
    endtask

    task automatic do_clr(input logic [NB:0] m);
        iclr_wr_en = 1'b1; iclr_wr_data = m; tick(); iclr_wr_en = 1'b0;
    endtask

    task automatic do_ien(input logic [NB:0] m);
        ien_wr_en = 1'b1; ien_wr_data = m; tick(); ien_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < NB; i++) begin
            check("R1 status", 32'(st(i)), 32'h0);
        end
        check("R1 prio", 32'(tx_prio_o == '0), 32'h1);
        check("R1 dlc", 32'(dlc_o == '0), 32'h1);
        check("R1 tx_req", 32'(tx_req_o), 32'h0);
        check("R1 ien", 32'(ien_o), 32'h0);
        check("R1 ipnd", 32'(ipnd_o), 32'h0);
        check("R1 irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_write();
        sw_wr(3, 4'b1000, 4'h5, 4'h8);
        check("R2 status", 32'(st(3)), 32'h8);
        check("R2 prio", 32'(pr(3)), 32'h5);
        check("R2 dlc", 32'(dl(3)), 32'h8);
        check("R2 other buffer untouched", 32'(st(4)), 32'h0);
        sw_wr(3, 4'b1001, 4'h2, 4'h1);
        check("R2 illegal code status", 32'(st(3)), 32'h8);
        check("R2 illegal code prio", 32'(pr(3)), 32'h5);
        sw_wr(3, 4'b1011, 4'h2, 4'h1);
        check("R2 illegal code 1011 dlc", 32'(dl(3)), 32'h8);
    endtask

    task automatic t_rx();
        sw_wr(2, 4'b0010, 4'h0, 4'h0);
        check("R3 armed", 32'(st(2)), 32'h2);
        do_hit(2);
        check("R3 copy busy", 32'(st(2)), 32'h3);
        check("R3 no pend yet", 32'(ipnd_o[2]), 32'h0);
        do_copy(2);
        check("R3 full", 32'(st(2)), 32'h4);
        check("R3 pend set", 32'(ipnd_o[2]), 32'h1);
        check("R12 irq masked", 32'(irq_o), 32'h0);
        do_ien(16'h0004);
        check("R12 ien", 32'(ien_o), 32'h0004);
        check("R12 irq on", 32'(irq_o), 32'h1);
        do_clr(16'h0004);
        check("R12 cleared", 32'(ipnd_o[2]), 32'h0);
        check("R12 irq off", 32'(irq_o), 32'h0);
    endtask

    task automatic t_overrun();
        do_hit(2);
        check("R4 second copy busy", 32'(st(2)), 32'h5);
        do_copy(2);
        check("R4 overrun", 32'(st(2)), 32'h6);
        check("R4 pend", 32'(ipnd_o[2]), 32'h1);
        do_clr(16'h0004);
        do_hit(2);
        check("R4 third copy busy", 32'(st(2)), 32'h7);
        do_copy(2);
        check("R4 stays overrun", 32'(st(2)), 32'h6);
        check("R4 pend again", 32'(ipnd_o[2]), 32'h1);
        do_clr(16'h0004);
        do_ien(16'h0000);
    endtask

    task automatic t_rx_locked();
        sw_wr(4, 4'b0010, 4'h0, 4'h0);
        do_hit(4);
        sw_wr(4, 4'b0000, 4'h0, 4'h0);
        check("R5 locked", 32'(st(4)), 32'h1);
        sw_wr(4, 4'b1100, 4'h3, 4'h3);
        check("R6 write ignored while locked", 32'(st(4)), 32'h1);
        do_copy(4);
        check("R5 off after copy", 32'(st(4)), 32'h0);
        check("R5 no pend", 32'(ipnd_o[4]), 32'h0);
    endtask

    task automatic t_lock();
        sw_wr(5, 4'b0010, 4'h1, 4'h2);
        do_hit(5);
        sw_wr(5, 4'b1000, 4'h7, 4'h3);
        check("R6 status held", 32'(st(5)), 32'h3);
        check("R6 prio held", 32'(pr(5)), 32'h1);
        check("R6 dlc held", 32'(dl(5)), 32'h2);
        do_copy(5);
        do_clr(16'h0020);
    endtask

    task automatic t_txonce();
        sw_wr(7, 4'b1100, 4'h9, 4'h4);
        check("R7 request", 32'(tx_req_o[7]), 32'h1);
        check("R7 prio", 32'(pr(7)), 32'h9);
        do_start(7);
        check("R7 busy", 32'(st(7)), 32'hD);
        check("R7 request dropped", 32'(tx_req_o[7]), 32'h0);
        sw_wr(7, 4'b0010, 4'h0, 4'h0);
        check("R6 tx busy write ignored", 32'(st(7)), 32'hD);
        do_txdone(7, 1'b0);
        check("R7 idle", 32'(st(7)), 32'h8);
        check("R7 pend", 32'(ipnd_o[7]), 32'h1);
        do_clr(16'h0080);
    endtask

    task automatic t_remote();
        sw_wr(8, 4'b1100, 4'h2, 4'h0);
        do_start(8);
        do_txdone(8, 1'b1);
        check("R8 armed after remote", 32'(st(8)), 32'h2);
        check("R8 pend", 32'(ipnd_o[8]), 32'h1);
        do_clr(16'h0100);
    endtask

    task automatic t_auto();
        sw_wr(14, 4'b1010, 4'h6, 4'h2);
        check("R9 auto no request", 32'(tx_req_o[14]), 32'h0);
        do_rtr(14);
        check("R9 send auto", 32'(st(14)), 32'hE);
        check("R9 request", 32'(tx_req_o[14]), 32'h1);
        do_start(14);
        check("R9 busy auto", 32'(st(14)), 32'hF);
        do_txdone(14, 1'b0);
        check("R9 back to auto", 32'(st(14)), 32'hA);
        check("R9 pend", 32'(ipnd_o[14]), 32'h1);
        do_clr(16'h4000);
    endtask

    task automatic t_ignore();
        do_hit(0);
        check("R10 hit on off buffer", 32'(st(0)), 32'h0);
        do_copy(0);
        check("R10 copy on off buffer", 32'(st(0)), 32'h0);
        check("R10 no pend", 32'(ipnd_o[0]), 32'h0);
        do_rtr(7);
        check("R10 rtr on idle tx", 32'(st(7)), 32'h8);
        do_start(7);
        check("R10 start on idle tx", 32'(st(7)), 32'h8);
        do_txdone(3, 1'b0);
        check("R10 done on idle tx", 32'(st(3)), 32'h8);
        check("R10 no pend on done", 32'(ipnd_o[3]), 32'h0);
    endtask

    task automatic t_collide();
        sw_wr(9, 4'b0010, 4'h0, 4'h0);
        sw_wr_en = 1'b1; sw_wr_idx = 4'd9; sw_wr_word = 16'h1058;
        hit_en = 1'b1; hit_idx = 4'd9;
        tick();
        sw_wr_en = 1'b0; hit_en = 1'b0;
        check("R11 event wins", 32'(st(9)), 32'h3);
        check("R11 prio not loaded", 32'(pr(9)), 32'h0);
    endtask

    task automatic t_irq();
        err_evt = 1'b1; tick(); err_evt = 1'b0;
        check("R12 error pend", 32'(ipnd_o[15]), 32'h1);
        err_evt = 1'b1; iclr_wr_en = 1'b1; iclr_wr_data = 16'h8000;
        tick();
        err_evt = 1'b0; iclr_wr_en = 1'b0;
        check("R12 set wins over clear", 32'(ipnd_o[15]), 32'h1);
        do_ien(16'h0001);
        check("R12 irq needs match", 32'(irq_o), 32'h0);
        do_ien(16'h8000);
        check("R12 error irq", 32'(irq_o), 32'h1);
        do_clr(16'h8000);
        check("R12 error cleared", 32'(ipnd_o), 32'h0);
        check("R12 irq low", 32'(irq_o), 32'h0);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_write();
        t_rx();
        t_overrun();
        t_rx_locked();
        t_lock();
        t_txonce();
        t_remote();
        t_auto();
        t_ignore();
        t_collide();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule